// File: doc/BRIEF.md
# Virtual Access Protection and Space Steering

This block sits beside the address translation path of a memory-management unit. For every virtual access it decides two things: whether the access goes to the instruction space or to the data space, and what the protection code of the selected page makes of the access. The protection outcome is one of three: the access proceeds silently, it proceeds with a trap request raised for the processor, or it is refused with an abort request. For every access that is not refused, the block also requests that the page's accessed flag be set.

Space steering depends on the addressing mode and register of the operand specifier. The register file index 7 is the program counter. Of the specifiers that use it, only the two that step past an inline word (autoincrement and autoincrement-deferred) are data references. Every other program-counter specifier, including the plain deferred form, reads the instruction stream. Accesses that target the unit's own control registers never raise a trap. Abort requests are later serviced through vector 250 (octal) by the surrounding logic.

The verdict is registered: an access presented with `req_valid` in one cycle produces its result on the `rsp_*` outputs in the next cycle. Relocation, the page-length check and the trap or abort sequencing are handled elsewhere.

Top module: `mmu_access_gate`

## Requirements
- R1: The result of an access offered with `req_valid` high appears exactly one clock later with `rsp_valid` high. In any cycle where `rsp_valid` is low, `rsp_dspace`, `rsp_abort`, `rsp_trap` and `rsp_mark_acc` are all low.
- R2: When `dspace_enable` is low, `rsp_dspace` is 0, meaning instruction space. When it is high and `spec_reg` is not 7, `rsp_dspace` is 1, meaning data space.
- R3: When `spec_reg` is 7 and `dspace_enable` is high, `rsp_dspace` is 1 only for `spec_mode` 2 (autoincrement) and 3 (autoincrement-deferred). It is 0 for every other mode, including 1 (deferred).
- R4: Protection codes 0, 3 and 7 abort both reads and writes (`req_write` 0 is a read, 1 is a write) and raise no trap.
- R5: Protection code 1 lets a read proceed with a trap request and aborts a write.
- R6: Protection code 2 lets a read proceed with no trap and aborts a write.
- R7: Protection code 4 lets any access proceed with a trap request. Code 5 lets any access proceed and traps only on writes. Code 6 lets any access proceed with no trap.
- R8: When `target_is_mmu_reg` is high, `rsp_trap` stays low whatever the protection code. Aborts are not affected.
- R9: `rsp_abort` and `rsp_trap` are never high in the same cycle.
- R10: `rsp_mark_acc` is high exactly when `rsp_valid` is high and `rsp_abort` is low.
- R11: While `rst` is high, all outputs are low one clock later, even with `req_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An access is offered this cycle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| spec_mode | input | 3 | Addressing mode of the operand specifier |
| spec_reg | input | 3 | Register number of the specifier (7 = program counter) |
| dspace_enable | input | 1 | Data space is enabled for the current processor mode |
| page_acf | input | 3 | Protection code of the selected page |
| target_is_mmu_reg | input | 1 | Access targets a memory-management control register |
| rsp_valid | output | 1 | Result present |
| rsp_dspace | output | 1 | 1 = data space, 0 = instruction space |
| rsp_abort | output | 1 | Abort request |
| rsp_trap | output | 1 | Trap request |
| rsp_mark_acc | output | 1 | Request to set the page's accessed flag |

## Verification
Directed cases step through all eight protection codes, each as a read and as a write and with and without the control-register flag. This separates each code's read behaviour from its write behaviour, and shows trap suppression apart from abort behaviour. A second directed sweep crosses every addressing mode with register 7 and with another register, with data space enabled and disabled. This isolates the program-counter exception from the general enable rule. Seeded random traffic, including idle cycles and back-to-back accesses, then checks the one-cycle timing, the clearing of outputs when idle, and the exclusivity of abort and trap across mixed input patterns.

// File: rtl/mmu_gate_pkg.sv
package mmu_gate_pkg;

    localparam int MODE_W = 3;
    localparam int REG_W  = 3;
    localparam int PROT_W = 3;

    localparam logic [REG_W-1:0]  PC_INDEX        = 3'd7;
    localparam logic [MODE_W-1:0] MODE_AUTOINC    = 3'd2;
    localparam logic [MODE_W-1:0] MODE_AUTOINC_DF = 3'd3;

    typedef enum logic [PROT_W-1:0] {
        PROT_DENY0     = 3'd0,
        PROT_RD_TRAP   = 3'd1,
        PROT_RD_ONLY   = 3'd2,
        PROT_DENY3     = 3'd3,
        PROT_RW_TRAP   = 3'd4,
        PROT_RW_TRAPWR = 3'd5,
        PROT_RW        = 3'd6,
        PROT_DENY7     = 3'd7
    } prot_code_e;

    typedef struct packed {
        logic deny;
        logic flag;
    } prot_verdict_t;

    typedef struct packed {
        logic valid;
        logic dspace;
        logic abort;
        logic trap;
        logic mark;
    } gate_result_t;

    function automatic prot_verdict_t judge_prot(prot_code_e code, logic is_wr);
        prot_verdict_t v;
        v = '0;
        unique case (code)
            PROT_RD_TRAP:   begin v.deny = is_wr; v.flag = ~is_wr; end
            PROT_RD_ONLY:   begin v.deny = is_wr; end
            PROT_RW_TRAP:   begin v.flag = 1'b1; end
            PROT_RW_TRAPWR: begin v.flag = is_wr; end
            PROT_RW:        begin end
            default:        begin v.deny = 1'b1; end
        endcase
        return v;
    endfunction

    function automatic logic pc_mode_is_data(logic [MODE_W-1:0] mode);
        return (mode == MODE_AUTOINC) || (mode == MODE_AUTOINC_DF);
    endfunction

endpackage

// File: rtl/mmu_space_sel.sv
module mmu_space_sel
    import mmu_gate_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [REG_W-1:0]  regnum,
    input  logic              d_on,
    output logic              use_d
);
    logic via_pc;

    always_comb begin
        via_pc = (regnum == PC_INDEX);
        if (!d_on)
            use_d = 1'b0;
        else if (via_pc)
            use_d = pc_mode_is_data(mode);
        else
            use_d = 1'b1;
    end
endmodule

// File: rtl/mmu_prot_check.sv
module mmu_prot_check
    import mmu_gate_pkg::*;
(
    input  logic [PROT_W-1:0] code,
    input  logic              is_wr,
    input  logic              to_mmu_reg,
    output logic              deny,
    output logic              flag
);
    prot_verdict_t v;

    always_comb begin
        v    = judge_prot(prot_code_e'(code), is_wr);
        deny = v.deny;
        flag = v.flag & ~v.deny & ~to_mmu_reg;
    end
endmodule

// File: rtl/mmu_access_gate.sv
module mmu_access_gate
    import mmu_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [MODE_W-1:0] spec_mode,
    input  logic [REG_W-1:0]  spec_reg,
    input  logic              dspace_enable,
    input  logic [PROT_W-1:0] page_acf,
    input  logic              target_is_mmu_reg,
    output logic              rsp_valid,
    output logic              rsp_dspace,
    output logic              rsp_abort,
    output logic              rsp_trap,
    output logic              rsp_mark_acc
);
    logic         sel_d;
    logic         chk_deny;
    logic         chk_flag;
    gate_result_t nxt;
    gate_result_t cur;

    mmu_space_sel u_space (
        .mode   (spec_mode),
        .regnum (spec_reg),
        .d_on   (dspace_enable),
        .use_d  (sel_d)
    );

    mmu_prot_check u_prot (
        .code       (page_acf),
        .is_wr      (req_write),
        .to_mmu_reg (target_is_mmu_reg),
        .deny       (chk_deny),
        .flag       (chk_flag)
    );

    always_comb begin
        nxt        = '0;
        nxt.valid  = req_valid;
        nxt.dspace = req_valid & sel_d;
        nxt.abort  = req_valid & chk_deny;
        nxt.trap   = req_valid & chk_flag;
        nxt.mark   = req_valid & ~chk_deny;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign rsp_valid    = cur.valid;
    assign rsp_dspace   = cur.dspace;
    assign rsp_abort    = cur.abort;
    assign rsp_trap     = cur.trap;
    assign rsp_mark_acc = cur.mark;

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(rsp_dspace || rsp_abort || rsp_trap || rsp_mark_acc));

    assert_ispace_when_off_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !dspace_enable) |=> !rsp_dspace);

    assert_pc_other_modes_ispace_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && spec_reg == PC_INDEX && spec_mode != MODE_AUTOINC
         && spec_mode != MODE_AUTOINC_DF) |=> !rsp_dspace);

    assert_deny_codes_abort_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (page_acf == 3'd0 || page_acf == 3'd3 || page_acf == 3'd7))
        |=> rsp_abort);

    assert_code1_read_traps_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && page_acf == 3'd1 && !req_write && !target_is_mmu_reg)
        |=> (rsp_trap && !rsp_abort));

    assert_code2_write_aborts_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && page_acf == 3'd2 && req_write) |=> rsp_abort);

    assert_code6_clean_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && page_acf == 3'd6) |=> (!rsp_abort && !rsp_trap));

    assert_mmu_reg_no_trap_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && target_is_mmu_reg) |=> !rsp_trap);

    assert_abort_trap_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $countones({rsp_abort, rsp_trap}) <= 1);

    assert_mark_needs_success_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_mark_acc |-> (rsp_valid && !rsp_abort));

    assert_reset_clears_R11: assert property (@(posedge clk)
        rst |=> !(rsp_valid || rsp_dspace || rsp_abort || rsp_trap || rsp_mark_acc));

endmodule

// File: tb/mmu_access_gate_tb_top.sv
module mmu_access_gate_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [2:0] spec_mode = '0;
    logic [2:0] spec_reg = '0;
    logic       dspace_enable = 1'b0;
    logic [2:0] page_acf = '0;
    logic       target_is_mmu_reg = 1'b0;
    logic       rsp_valid, rsp_dspace, rsp_abort, rsp_trap, rsp_mark_acc;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    bit    have_exp = 0;
    bit    e_valid, e_d, e_ab, e_tr, e_mk;
    string t_d, t_prot;

    always #5 clk = ~clk;

    mmu_access_gate dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .spec_mode(spec_mode), .spec_reg(spec_reg), .dspace_enable(dspace_enable),
        .page_acf(page_acf), .target_is_mmu_reg(target_is_mmu_reg),
        .rsp_valid(rsp_valid), .rsp_dspace(rsp_dspace), .rsp_abort(rsp_abort),
        .rsp_trap(rsp_trap), .rsp_mark_acc(rsp_mark_acc)
    );

    task automatic check(logic act, logic exp, string tag, string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // Expected protection outcome, written from R4..R7 (abort, raw trap)
    function automatic void model_prot(logic [2:0] c, logic w, output bit ab, output bit tr);
        ab = 0; tr = 0;
        case (c)
            3'd1: if (w) ab = 1; else tr = 1;   // R5
            3'd2: if (w) ab = 1;                // R6
            3'd4: tr = 1;                       // R7
            3'd5: tr = w;                       // R7
            3'd6: ;                             // R7
            default: ab = 1;                    // R4: 0,3,7
        endcase
    endfunction

    function automatic string prot_tag(logic [2:0] c);
        if (c == 3'd0 || c == 3'd3 || c == 3'd7) return "R4";
        if (c == 3'd1) return "R5";
        if (c == 3'd2) return "R6";
        return "R7";
    endfunction

    task automatic verify_pending();
        if (!have_exp) return;
        check(rsp_valid, e_valid, "R1", "rsp_valid");
        check(rsp_dspace, e_d, t_d, "rsp_dspace");
        check(rsp_abort, e_ab, t_prot, "rsp_abort");
        check(rsp_trap, e_tr, t_prot, "rsp_trap");
        check(rsp_mark_acc, e_mk, "R10", "rsp_mark_acc");
        check(rsp_abort & rsp_trap, 1'b0, "R9", "abort&trap");
    endtask

    task automatic step(bit v, bit w, logic [2:0] m, logic [2:0] r, bit en,
                        logic [2:0] c, bit mmu);
        bit ab, tr;
        @(negedge clk);
        verify_pending();
        req_valid = v; req_write = w; spec_mode = m; spec_reg = r;
        dspace_enable = en; page_acf = c; target_is_mmu_reg = mmu;
        model_prot(c, w, ab, tr);
        if (mmu) tr = 0;                       // R8
        e_valid = v;
        // R2 / R3 space rule
        if (!en)           e_d = 0;
        else if (r == 3'd7) e_d = (m == 3'd2) || (m == 3'd3);
        else               e_d = 1;
        e_d  = e_d & v;
        e_ab = ab & v;
        e_tr = tr & v;
        e_mk = v & ~ab;                        // R10
        t_d  = (en && r == 3'd7) ? "R3" : "R2";
        t_prot = (mmu && !ab) ? "R8" : prot_tag(c);
        have_exp = 1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R11: reset with a request pending must keep outputs low
        rst = 1; req_valid = 1; page_acf = 3'd6; dspace_enable = 1;
        repeat (3) @(negedge clk);
        check(rsp_valid, 1'b0, "R11", "reset rsp_valid");
        check(rsp_mark_acc, 1'b0, "R11", "reset rsp_mark_acc");
        check(rsp_dspace, 1'b0, "R11", "reset rsp_dspace");
        check(rsp_abort | rsp_trap, 1'b0, "R11", "reset abort|trap");
        req_valid = 0;
        rst = 0;

        // R4..R8: every protection code, read/write, with/without mmu target
        for (int c = 0; c < 8; c++)
            for (int w = 0; w < 2; w++)
                for (int mm = 0; mm < 2; mm++)
                    step(1, w[0], 3'd1, 3'd0, 1, c[2:0], mm[0]);

        // R2/R3: every mode with PC and a general register, enable on/off
        for (int m = 0; m < 8; m++)
            for (int en = 0; en < 2; en++) begin
                step(1, 0, m[2:0], 3'd7, en[0], 3'd6, 0);
                step(1, 0, m[2:0], 3'd4, en[0], 3'd6, 0);
            end

        // R1: idle cycle between requests
        step(0, 1, 3'd2, 3'd7, 1, 3'd4, 0);
        step(1, 1, 3'd3, 3'd7, 1, 3'd5, 0);
        step(0, 0, 3'd0, 3'd0, 0, 3'd0, 0);

        // Seeded random traffic
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            step(rv[0] | rv[1], rv[2], rv[5:3], rv[8:6], rv[9] | rv[10],
                 rv[13:11], rv[14] & rv[15]);
        end
        @(negedge clk);
        verify_pending();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule